// File: doc/BRIEF.md
# RV32I Instruction Decoder and Immediate Generator

This block takes one 32-bit instruction word of a 31-instruction subset of the base integer ISA and produces everything a single-cycle core needs to execute it. It picks out the three register indices. It rebuilds the sign-extended immediate from whichever of five scattered layouts the instruction format uses. It chooses an ALU operation code and sets the control strobes for register write-back, data memory access, operand selection and control transfer.

The decoder is purely combinational, so a core places it between instruction fetch and its register file and ALU. The covered instructions are the register-register ALU group, the ALU-with-immediate group including the immediate shifts, word load and store, the six conditional branches, the two jumps, and the two upper-immediate instructions. An opcode or funct3 that the block does not recognise leaves every write, memory and transfer strobe low, so the core treats the word as a no-op.

Top module: `rvdec_top`

## Requirements
- R1: rs1 is always instr[19:15], rs2 is always instr[24:20] and rd is always instr[11:7], whatever the opcode.
- R2: Load, ALU-with-immediate (opcode 0010011) and JALR produce the immediate instr[31:20], sign-extended from bit 31.
- R3: Store produces the immediate {instr[31:25], instr[11:7]}, sign-extended from bit 31.
- R4: A conditional branch produces the immediate {instr[31], instr[7], instr[30:25], instr[11:8], 0}, sign-extended; its bit 0 is always 0.
- R5: LUI and AUIPC produce the immediate {instr[31:12], twelve zero bits}.
- R6: JAL produces the immediate {instr[31], instr[19:12], instr[20], instr[30:21], 0}, sign-extended; its bit 0 is always 0.
- R7: Opcode 0110011 sets reg_wr, sets the write-back select to ALU (code 0), uses the register for operand B and produces immediate 0. funct3 picks the ALU code from 000 add(0)/sub(1), 001 sll(2), 010 slt(3), 011 sltu(4), 100 xor(5), 101 srl(6)/sra(7), 110 or(8) and 111 and(9). Bit 30 selects sub and sra, and it matters only for funct3 000 and 101.
- R8: Opcode 0010011 sets reg_wr and selects the immediate for operand B, with the same funct3 to ALU code mapping as R7. Bit 30 selects sra only for funct3 101. funct3 000 is always add(0), whatever bit 30 holds.
- R9: Opcode 0000011 with funct3 010 sets reg_wr and mem_rd, selects the immediate for operand B, uses ALU add and sets the write-back select to memory (code 1). Opcode 0100011 with funct3 010 sets mem_wr only, with the immediate for operand B and ALU add.
- R10: Opcode 1100011 sets branch, with the register for operand B and no register or memory write. funct3 picks the compare code from 000 eq(10), 001 ne(11), 100 slt(3), 101 ge(12), 110 sltu(4) and 111 geu(13). funct3 010 and 011 are unrecognised.
- R11: JAL (1101111) sets jump, reg_wr and opa_pc. JALR (1100111 with funct3 000) sets jump_reg and reg_wr. Both select the immediate for operand B, use ALU add and set the write-back select to PC+4 (code 2).
- R12: LUI (0110111) sets reg_wr, selects the immediate for operand B and uses ALU code pass-B (14). AUIPC (0010111) sets reg_wr, opa_pc and the immediate for operand B, and uses ALU add.
- R13: An unrecognised opcode, or a recognised opcode with an unsupported funct3 (load, store, JALR, branch), drives every strobe low, the write-back select to 0, the ALU code to add(0) and the immediate to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| rd_idx_o | output | 5 | Destination register index |
| imm_o | output | XLEN (32) | Reassembled, extended immediate |
| alu_op_o | output | 4 | ALU operation code |
| reg_wr_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| opb_imm_o | output | 1 | Operand B comes from the immediate |
| opa_pc_o | output | 1 | Operand A comes from the PC |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | PC-relative jump |
| jump_reg_o | output | 1 | Register-indirect jump |

## Verification
Every output is a pure function of the instruction word, so each result is due in the same cycle as its stimulus, with no register anywhere in the path. The bench drives a new word just after each rising clock edge and compares all outputs at the following falling edge, half a period later. This keeps sampling clear of the edge and lets the decode logic settle completely before the check. The words cover each of the 31 instructions with random fields, directed cases for bit 30 and unsupported funct3 values, and fully random words.

// File: rtl/rvdec_pkg.sv
// Package: shared encodings for the instruction decoder.
// Assumes a 32-bit instruction word with a 7-bit major opcode in [6:0].
package rvdec_pkg;
    localparam int ILEN   = 32;
    localparam int REG_AW = 5;
    localparam int OPC_W  = 7;

    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0,  ALU_SUB = 4'd1,  ALU_SLL = 4'd2,  ALU_SLT = 4'd3,
        ALU_SLTU = 4'd4, ALU_XOR = 4'd5,  ALU_SRL = 4'd6,  ALU_SRA = 4'd7,
        ALU_OR = 4'd8,   ALU_AND = 4'd9,  ALU_EQ = 4'd10,  ALU_NE = 4'd11,
        ALU_GE = 4'd12,  ALU_GEU = 4'd13, ALU_PASSB = 4'd14
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC4 = 2'd2
    } wb_sel_e;

    typedef enum logic [2:0] {
        FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
    } imm_fmt_e;

    typedef struct packed {
        logic     reg_wr;
        logic     mem_rd;
        logic     mem_wr;
        logic     opb_imm;
        logic     opa_pc;
        logic     branch;
        logic     jump;
        logic     jump_reg;
        wb_sel_e  wb_sel;
        imm_fmt_e fmt;
    } ctrl_t;
endpackage

// File: rtl/rvdec_imm_gen.sv
// Immediate generator: gathers the scattered immediate bits of the chosen
// format and extends them to XLEN. Assumes XLEN >= 32; FMT_NONE gives zero.
module rvdec_imm_gen
    import rvdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr_i,
    input  imm_fmt_e        fmt_i,
    output logic [XLEN-1:0] imm_o
);
    localparam int EXT_I = XLEN - 12;
    localparam int EXT_B = XLEN - 13;
    localparam int EXT_J = XLEN - 21;
    localparam int EXT_U = XLEN - 32;

    logic sgn;
    assign sgn = instr_i[ILEN-1];

    // Select and extend the immediate for the decoded format.
    always_comb begin
        unique case (fmt_i)
            FMT_I:   imm_o = {{EXT_I{sgn}}, instr_i[31:20]};
            FMT_S:   imm_o = {{EXT_I{sgn}}, instr_i[31:25], instr_i[11:7]};
            FMT_B:   imm_o = {{EXT_B{sgn}}, instr_i[31], instr_i[7],
                              instr_i[30:25], instr_i[11:8], 1'b0};
            FMT_J:   imm_o = {{EXT_J{sgn}}, instr_i[31], instr_i[19:12],
                              instr_i[20], instr_i[30:21], 1'b0};
            FMT_U:   imm_o = XLEN'({{EXT_U{sgn}}, instr_i[31:12], 12'b0});
            default: imm_o = '0;
        endcase
    end

    // Upper-immediate output keeps its low twelve bits clear.
    always_comb begin
        a_r5_upper_low_zero: assert (fmt_i != FMT_U || imm_o[11:0] == 12'b0)
            else $error("upper immediate has nonzero low bits");
    end
endmodule

// File: rtl/rvdec_ctrl.sv
// Main control: turns opcode and funct3 into the strobe bundle and the
// immediate format. Assumes the caller drives all strobes low for any
// word it cannot decode, which this module guarantees with its default.
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [2:0]       funct3_i,
    output ctrl_t            ctrl_o
);
    // Decode the control bundle; unknown words keep the all-zero default.
    always_comb begin
        ctrl_o = '{reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, opb_imm: 1'b0,
                   opa_pc: 1'b0, branch: 1'b0, jump: 1'b0, jump_reg: 1'b0,
                   wb_sel: WB_ALU, fmt: FMT_NONE};
        unique case (opcode_i)
            OPC_OP: ctrl_o.reg_wr = 1'b1;
            OPC_OPIMM: begin
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.opb_imm = 1'b1;
                ctrl_o.fmt     = FMT_I;
            end
            OPC_LOAD: if (funct3_i == 3'b010) begin
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.mem_rd  = 1'b1;
                ctrl_o.opb_imm = 1'b1;
                ctrl_o.wb_sel  = WB_MEM;
                ctrl_o.fmt     = FMT_I;
            end
            OPC_STORE: if (funct3_i == 3'b010) begin
                ctrl_o.mem_wr  = 1'b1;
                ctrl_o.opb_imm = 1'b1;
                ctrl_o.fmt     = FMT_S;
            end
            OPC_BRANCH: if (funct3_i[2:1] != 2'b01) begin
                ctrl_o.branch = 1'b1;
                ctrl_o.fmt    = FMT_B;
            end
            OPC_JAL: begin
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.opa_pc  = 1'b1;
                ctrl_o.opb_imm = 1'b1;
                ctrl_o.jump    = 1'b1;
                ctrl_o.wb_sel  = WB_PC4;
                ctrl_o.fmt     = FMT_J;
            end
            OPC_JALR: if (funct3_i == 3'b000) begin
                ctrl_o.reg_wr   = 1'b1;
                ctrl_o.opb_imm  = 1'b1;
                ctrl_o.jump_reg = 1'b1;
                ctrl_o.wb_sel   = WB_PC4;
                ctrl_o.fmt      = FMT_I;
            end
            OPC_LUI, OPC_AUIPC: begin
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.opb_imm = 1'b1;
                ctrl_o.opa_pc  = (opcode_i == OPC_AUIPC);
                ctrl_o.fmt     = FMT_U;
            end
            default: ;
        endcase
    end

    // Strobes that must never coexist.
    always_comb begin
        a_r9_rd_wr_exclusive: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
            else $error("memory read and write together");
        a_r10_transfer_onehot: assert ($onehot0({ctrl_o.branch, ctrl_o.jump, ctrl_o.jump_reg}))
            else $error("more than one control transfer");
        a_r10_branch_no_write: assert (!ctrl_o.branch || (!ctrl_o.reg_wr && !ctrl_o.mem_wr))
            else $error("branch writes state");
    end
endmodule

// File: rtl/rvdec_alu_sel.sv
// ALU operation select: maps opcode, funct3 and instruction bit 30 to an
// ALU code. Bit 30 is honoured only where the format leaves it free of
// immediate bits. Assumes the caller gates unsupported words via control.
module rvdec_alu_sel
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [2:0]       funct3_i,
    input  logic             bit30_i,
    output alu_op_e          alu_op_o
);
    // Shared funct3 mapping for the two arithmetic groups.
    function automatic alu_op_e arith_op(input logic [2:0] f3, input logic sub_ok,
                                         input logic b30);
        unique case (f3)
            3'b000:  arith_op = (sub_ok && b30) ? ALU_SUB : ALU_ADD;
            3'b001:  arith_op = ALU_SLL;
            3'b010:  arith_op = ALU_SLT;
            3'b011:  arith_op = ALU_SLTU;
            3'b100:  arith_op = ALU_XOR;
            3'b101:  arith_op = b30 ? ALU_SRA : ALU_SRL;
            3'b110:  arith_op = ALU_OR;
            default: arith_op = ALU_AND;
        endcase
    endfunction

    // Pick the ALU code per opcode group.
    always_comb begin
        alu_op_o = ALU_ADD;
        unique case (opcode_i)
            OPC_OP:    alu_op_o = arith_op(funct3_i, 1'b1, bit30_i);
            OPC_OPIMM: alu_op_o = arith_op(funct3_i, 1'b0, bit30_i);
            OPC_LUI:   alu_op_o = ALU_PASSB;
            OPC_BRANCH: begin
                unique case (funct3_i)
                    3'b000:  alu_op_o = ALU_EQ;
                    3'b001:  alu_op_o = ALU_NE;
                    3'b100:  alu_op_o = ALU_SLT;
                    3'b101:  alu_op_o = ALU_GE;
                    3'b110:  alu_op_o = ALU_SLTU;
                    3'b111:  alu_op_o = ALU_GEU;
                    default: alu_op_o = ALU_ADD;
                endcase
            end
            default: alu_op_o = ALU_ADD;
        endcase
    end

    // Subtract is reachable only from the register-register group.
    always_comb begin
        a_r8_sub_only_reg_reg: assert (alu_op_o != ALU_SUB || opcode_i == OPC_OP)
            else $error("subtract decoded outside register-register group");
    end
endmodule

// File: rtl/rvdec_top.sv
// Top: combinational RV32I decoder. Splits out register fields, builds the
// immediate, picks the ALU code and the control strobes. Assumes a valid
// instruction word each cycle; it holds no state, so there is no reset.
module rvdec_top
    import rvdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0]   instr_i,
    output logic [REG_AW-1:0] rs1_idx_o,
    output logic [REG_AW-1:0] rs2_idx_o,
    output logic [REG_AW-1:0] rd_idx_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [3:0]        alu_op_o,
    output logic              reg_wr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              opb_imm_o,
    output logic              opa_pc_o,
    output logic [1:0]        wb_sel_o,
    output logic              branch_o,
    output logic              jump_o,
    output logic              jump_reg_o
);
    ctrl_t   ctrl;
    alu_op_e alu_op;

    assign rs1_idx_o = instr_i[19:15];
    assign rs2_idx_o = instr_i[24:20];
    assign rd_idx_o  = instr_i[11:7];

    rvdec_ctrl u_ctrl (
        .opcode_i (instr_i[OPC_W-1:0]),
        .funct3_i (instr_i[14:12]),
        .ctrl_o   (ctrl)
    );

    rvdec_alu_sel u_alu_sel (
        .opcode_i (instr_i[OPC_W-1:0]),
        .funct3_i (instr_i[14:12]),
        .bit30_i  (instr_i[30]),
        .alu_op_o (alu_op)
    );

    rvdec_imm_gen #(.XLEN(XLEN)) u_imm (
        .instr_i (instr_i),
        .fmt_i   (ctrl.fmt),
        .imm_o   (imm_o)
    );

    assign alu_op_o   = alu_op;
    assign reg_wr_o   = ctrl.reg_wr;
    assign mem_rd_o   = ctrl.mem_rd;
    assign mem_wr_o   = ctrl.mem_wr;
    assign opb_imm_o  = ctrl.opb_imm;
    assign opa_pc_o   = ctrl.opa_pc;
    assign wb_sel_o   = ctrl.wb_sel;
    assign branch_o   = ctrl.branch;
    assign jump_o     = ctrl.jump;
    assign jump_reg_o = ctrl.jump_reg;

    // Cross-module checks between control and immediate paths.
    always_comb begin
        a_r4_branch_even: assert (!branch_o || !imm_o[0])
            else $error("branch offset odd");
        a_r6_jump_even: assert (!jump_o || !imm_o[0])
            else $error("jump offset odd");
        a_r13_idle_no_imm: assert (reg_wr_o || mem_wr_o || branch_o || imm_o == '0)
            else $error("immediate on unrecognised word");
    end
endmodule

// File: tb/rvdec_top_bench.sv
// Bench: random and directed instruction words against a reference model.
module rvdec_top_bench;
    localparam int XLEN = 32;
    localparam int REPS = 24;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] instr;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;
    logic [3:0]  alu;
    logic        reg_wr, mem_rd, mem_wr, opb_imm, opa_pc, branch, jump, jump_reg;
    logic [1:0]  wb_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rvdec_top #(.XLEN(XLEN)) u_rvdec_top (
        .instr_i (instr), .rs1_idx_o (rs1), .rs2_idx_o (rs2), .rd_idx_o (rd),
        .imm_o (imm), .alu_op_o (alu), .reg_wr_o (reg_wr), .mem_rd_o (mem_rd),
        .mem_wr_o (mem_wr), .opb_imm_o (opb_imm), .opa_pc_o (opa_pc),
        .wb_sel_o (wb_sel), .branch_o (branch), .jump_o (jump),
        .jump_reg_o (jump_reg)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s instr=%h got=%h exp=%h", tag, what, instr, got, exp);
        end
    endtask

    // Reference model written from the requirement text.
    task automatic model(input logic [31:0] w, output logic [31:0] e_imm,
                         output logic [3:0] e_alu, output logic [9:0] e_ctl,
                         output string ctag, output string itag);
        logic [6:0] op;
        logic [2:0] f3;
        logic [31:0] ii, is, ib, iu, ij;
        logic rw, mr, mw, ob, oa, br, jp, jr;
        logic [1:0] wb;
        op = w[6:0];
        f3 = w[14:12];
        ii = {{20{w[31]}}, w[31:20]};
        is = {{20{w[31]}}, w[31:25], w[11:7]};
        ib = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        iu = {w[31:12], 12'b0};
        ij = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        {rw, mr, mw, ob, oa, br, jp, jr} = '0;
        wb = 2'd0; e_imm = 32'd0; e_alu = 4'd0; ctag = "R13"; itag = "R13";
        case (op)
            7'h33: begin
                rw = 1; ctag = "R7"; itag = "R7";
                case (f3)
                    3'd0: e_alu = w[30] ? 4'd1 : 4'd0;
                    3'd1: e_alu = 4'd2;  3'd2: e_alu = 4'd3;
                    3'd3: e_alu = 4'd4;  3'd4: e_alu = 4'd5;
                    3'd5: e_alu = w[30] ? 4'd7 : 4'd6;
                    3'd6: e_alu = 4'd8;  default: e_alu = 4'd9;
                endcase
            end
            7'h13: begin
                rw = 1; ob = 1; e_imm = ii; ctag = "R8"; itag = "R2";
                case (f3)
                    3'd0: e_alu = 4'd0;
                    3'd1: e_alu = 4'd2;  3'd2: e_alu = 4'd3;
                    3'd3: e_alu = 4'd4;  3'd4: e_alu = 4'd5;
                    3'd5: e_alu = w[30] ? 4'd7 : 4'd6;
                    3'd6: e_alu = 4'd8;  default: e_alu = 4'd9;
                endcase
            end
            7'h03: if (f3 == 3'd2) begin
                rw = 1; mr = 1; ob = 1; wb = 2'd1; e_imm = ii; ctag = "R9"; itag = "R2";
            end
            7'h23: if (f3 == 3'd2) begin
                mw = 1; ob = 1; e_imm = is; ctag = "R9"; itag = "R3";
            end
            7'h63: if (f3 != 3'd2 && f3 != 3'd3) begin
                br = 1; e_imm = ib; ctag = "R10"; itag = "R4";
                case (f3)
                    3'd0: e_alu = 4'd10; 3'd1: e_alu = 4'd11;
                    3'd4: e_alu = 4'd3;  3'd5: e_alu = 4'd12;
                    3'd6: e_alu = 4'd4;  default: e_alu = 4'd13;
                endcase
            end
            7'h6F: begin
                rw = 1; oa = 1; ob = 1; jp = 1; wb = 2'd2; e_imm = ij; ctag = "R11"; itag = "R6";
            end
            7'h67: if (f3 == 3'd0) begin
                rw = 1; ob = 1; jr = 1; wb = 2'd2; e_imm = ii; ctag = "R11"; itag = "R2";
            end
            7'h37: begin
                rw = 1; ob = 1; e_alu = 4'd14; e_imm = iu; ctag = "R12"; itag = "R5";
            end
            7'h17: begin
                rw = 1; oa = 1; ob = 1; e_imm = iu; ctag = "R12"; itag = "R5";
            end
            default: ;
        endcase
        e_ctl = {rw, mr, mw, ob, oa, br, jp, jr, wb};
    endtask

    // Drive one word after a rising edge, check at the falling edge.
    task automatic apply(input logic [31:0] w);
        logic [31:0] e_imm;
        logic [3:0]  e_alu;
        logic [9:0]  e_ctl;
        string ctag, itag;
        @(posedge clk);
        #1 instr = w;
        model(w, e_imm, e_alu, e_ctl, ctag, itag);
        @(negedge clk);
        check("R1", "rs1", {27'd0, rs1}, {27'd0, w[19:15]});
        check("R1", "rs2", {27'd0, rs2}, {27'd0, w[24:20]});
        check("R1", "rd",  {27'd0, rd},  {27'd0, w[11:7]});
        check(itag, "imm", imm, e_imm);
        check(ctag, "alu", {28'd0, alu}, {28'd0, e_alu});
        check(ctag, "ctl",
              {22'd0, reg_wr, mem_rd, mem_wr, opb_imm, opa_pc, branch, jump, jump_reg, wb_sel},
              {22'd0, e_ctl});
    endtask

    // Build one encoding of instruction kind k (0..30) with random fields.
    function automatic logic [31:0] build(input int k, input logic [31:0] r);
        logic [31:0] w;
        logic [2:0] tab_r [10] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd7};
        logic [2:0] tab_i [9]  = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd6, 3'd7, 3'd1, 3'd5, 3'd5};
        logic [2:0] tab_b [6]  = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
        w = r;
        if (k < 10) begin
            w[6:0] = 7'h33; w[14:12] = tab_r[k];
            w[31:25] = (k == 1 || k == 7) ? 7'h20 : 7'h00;
        end else if (k < 19) begin
            w[6:0] = 7'h13; w[14:12] = tab_i[k-10];
            if (k >= 16) w[31:25] = (k == 18) ? 7'h20 : 7'h00;
        end else if (k == 19) begin
            w[6:0] = 7'h03; w[14:12] = 3'd2;
        end else if (k == 20) begin
            w[6:0] = 7'h23; w[14:12] = 3'd2;
        end else if (k < 27) begin
            w[6:0] = 7'h63; w[14:12] = tab_b[k-21];
        end else if (k == 27) begin
            w[6:0] = 7'h6F;
        end else if (k == 28) begin
            w[6:0] = 7'h67; w[14:12] = 3'd0;
        end else if (k == 29) begin
            w[6:0] = 7'h37;
        end else begin
            w[6:0] = 7'h17;
        end
        return w;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        instr = 32'd0;
        // R13: all-zero word is unrecognised
        apply(32'h0000_0000);
        // R13: all-ones word is unrecognised
        apply(32'hFFFF_FFFF);
        // R8: ADDI with bit 30 set and negative immediate stays add
        apply(32'hC000_0093);
        // R7: SUB versus a funct3 100 word with bit 30 set (bit 30 ignored)
        apply(32'h4020_80B3);
        apply(32'h4020_C0B3);
        // R10/R13: branch funct3 010 and 011 unsupported
        apply(32'h0000_2063);
        apply(32'hFE00_3FE3);
        // R13: JALR, load and store with unsupported funct3
        apply(32'h0000_1067);
        apply(32'hFFF0_0003);
        apply(32'hFFF0_1023);
        // R4/R6: extreme offsets of branch and jump
        apply(32'hFFFF_FFE3 & 32'hFFFF_8FFF);
        apply(32'h8000_006F);
        apply(32'h7FFF_F06F);
        // R5: upper immediate with sign bit set
        apply(32'h8000_0037);
        for (int rep = 0; rep < REPS; rep++) begin
            for (int k = 0; k < 31; k++) apply(build(k, $urandom));
        end
        for (int n = 0; n < 200; n++) apply($urandom);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule